// File: doc/BRIEF.md
# Two-channel PWM output controller

This peripheral drives two pins, each with its own pulse-width waveform, and a processor configures it through a small 32-bit register bus. Each channel holds an 8-bit high-time value and an 8-bit period value. The channel counts pulses of its own base-rate enable input, so one output period lasts (period + 1) enable pulses and the pin is high for the first "high-time" pulses of each period. A high-time larger than the period gives a constant high level. The base-rate enables come from a separate variable-frequency generator outside this block. Per channel, a selector routes either the generated waveform or that generator's raw signal to the pin.

A 4-bit field per channel in the control register holds the channel's run bit, an active-low drive enable, a force-high override and an open-drain mode. New timing values take effect only when the running period ends, so a rewrite never produces a runt pulse. In open-drain mode the block never drives the pin high. It enables the pad driver only while the level is low and releases the pad for a high level.

Top module: `pwm2_ctrl`

## Requirements
- R1: Register map with 8-bit offsets.
  - Control at 0x00: channel n uses bits 4n..4n+3, which are run (+0), drive-enable active-low (+1), force-high (+2) and open-drain (+3).
  - Selector at 0x04: bit 4n is 1 for the generated waveform and 0 for the raw input.
  - High-time for channel n at 0x18+8n and period at 0x1C+8n, each in bits 7:0.
  - Read data appears on `bus_rdata` in the cycle after `bus_rd` and reads back the written value. Unused bits read as 0.
  - After reset, control reads 0x22, selector reads 0x11 and the timing values read 0. Both outputs are low.
- R2: A read of any other offset returns 0. A write to any other offset changes no register.
- R3: With the waveform selected and the channel running, one period lasts (period+1) enable pulses and the pin is high during "high-time" pulses of it.
- R4: When high-time exceeds period (for example 0xFF and 0xFE), the pin stays high continuously.
- R5: While run is 0, the channel counter stays at zero and, with the waveform selected, the pin is low.
- R6: While run and force-high are both set, with the waveform selected, the pin is high whatever the timing values are.
- R7: With the selector bit at 0 (not open-drain), the pin follows `var_sig` with one cycle of delay.
- R8: In push-pull mode, `pad_oe` is 1 exactly when the active-low drive-enable bit is 0, one cycle after the control changes.
- R9: In open-drain mode, `pwm_out` is 0. `pad_oe` is 1 only while the drive-enable bit is 0 and the selected level is low.
- R10: Rewritten high-time and period values reach a running counter only at the end of the current period. While the channel is stopped, they load at once.
- R11: Without enable pulses, a running counter holds its value and the pin holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| rate_tick | input | 2 | Base-rate enable pulse per channel |
| var_sig | input | 2 | Raw variable-frequency signal per channel |
| pwm_out | output | 2 | Registered pin level per channel |
| pad_oe | output | 2 | Registered pad drive enable per channel, active high |

## Verification
On every cycle, the checker confirms these properties:
- A stopped counter is held at zero.
- The counter never passes its active period.
- Open-drain mode never drives a high level.
- A disabled driver keeps `pad_oe` low.
- Force-high yields a high pin.
- The raw path follows `var_sig` one cycle later.

Only the bench's scenarios can show the duty ratios, the constant-high case, the register read-back and the unmapped offsets. The same holds for the deferral of new timing values to the end of a period and the hold of the level while no enable pulses arrive.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int FIELD_W   = 4;
  localparam int B_RUN     = 0;
  localparam int B_OE_N    = 1;
  localparam int B_FORCE   = 2;
  localparam int B_ODRAIN  = 3;
  localparam int CTRL_OFF  = 'h00;
  localparam int SEL_OFF   = 'h04;
  localparam int HIGH_BASE = 'h18;
  localparam int PER_BASE  = 'h1C;
  localparam int CH_STRIDE = 8;
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CH*FIELD_W-1:0]     ctrl_o,
  output logic [NUM_CH-1:0]             sel_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  high_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  per_o
);
  localparam int CTRL_W = NUM_CH * FIELD_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFF);

  function automatic logic [CTRL_W-1:0] ctrl_reset();
    logic [CTRL_W-1:0] r;
    r = '0;
    for (int n = 0; n < NUM_CH; n++) r[n*FIELD_W + B_OE_N] = 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] high_addr(input int n);
    return ADDR_W'(HIGH_BASE + n * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] per_addr(input int n);
    return ADDR_W'(PER_BASE + n * CH_STRIDE);
  endfunction

  logic [CTRL_W-1:0]             ctrl_q;
  logic [NUM_CH-1:0]             sel_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  high_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  per_q;
  logic [DATA_W-1:0]             rdata_q;
  logic [DATA_W-1:0]             rd_val;
  logic                          unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  always_comb begin
    rd_val = '0;
    if (bus_addr == CTRL_A) rd_val[CTRL_W-1:0] = ctrl_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == SEL_A)        rd_val[n*FIELD_W]  = sel_q[n];
      if (bus_addr == high_addr(n)) rd_val[CNT_W-1:0]  = high_q[n];
      if (bus_addr == per_addr(n))  rd_val[CNT_W-1:0]  = per_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= ctrl_reset();
      sel_q   <= '1;
      high_q  <= '0;
      per_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= bus_rd ? rd_val : '0;
      if (bus_wr) begin
        if (bus_addr == CTRL_A) ctrl_q <= bus_wdata[CTRL_W-1:0];
        for (int n = 0; n < NUM_CH; n++) begin
          if (bus_addr == SEL_A)        sel_q[n]  <= bus_wdata[n*FIELD_W];
          if (bus_addr == high_addr(n)) high_q[n] <= bus_wdata[CNT_W-1:0];
          if (bus_addr == per_addr(n))  per_q[n]  <= bus_wdata[CNT_W-1:0];
        end
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign ctrl_o    = ctrl_q;
  assign sel_o     = sel_q;
  assign high_o    = high_q;
  assign per_o     = per_q;
endmodule

// File: rtl/pwm2_chan_gen.sv
module pwm2_chan_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] high_cfg,
  input  logic [CNT_W-1:0] per_cfg,
  output logic             wave_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_per_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_high_q;
  logic [CNT_W-1:0] act_per_q;
  logic             at_end;

  assign at_end = (cnt_q == act_per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      act_high_q <= '0;
      act_per_q  <= '0;
    end else if (!run) begin
      cnt_q      <= '0;
      act_high_q <= high_cfg;
      act_per_q  <= per_cfg;
    end else if (tick) begin
      if (at_end) begin
        cnt_q      <= '0;
        act_high_q <= high_cfg;
        act_per_q  <= per_cfg;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wave_o    = (cnt_q < act_high_q);
  assign cnt_o     = cnt_q;
  assign act_per_o = act_per_q;
endmodule

// File: rtl/pwm2_pad.sv
module pwm2_pad (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic force_hi,
  input  logic oe_n,
  input  logic open_drain,
  input  logic use_const,
  input  logic wave,
  input  logic var_in,
  output logic pin_o,
  output logic oe_o
);
  logic level;
  logic pin_q;
  logic oe_q;

  assign level = use_const ? (run & (force_hi | wave)) : var_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= open_drain ? 1'b0 : level;
      oe_q  <= !oe_n && (open_drain ? !level : 1'b1);
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] rate_tick,
  input  logic [NUM_CH-1:0] var_sig,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pad_oe
);
  logic [NUM_CH*FIELD_W-1:0]    ctrl_q;
  logic [NUM_CH-1:0]            sel_q;
  logic [NUM_CH-1:0][CNT_W-1:0] high_q;
  logic [NUM_CH-1:0][CNT_W-1:0] per_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_CH-1:0][CNT_W-1:0] act_per_w;
  logic [NUM_CH-1:0]            wave_w;

  pwm2_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_o(ctrl_q), .sel_o(sel_q), .high_o(high_q), .per_o(per_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm2_chan_gen #(.CNT_W(CNT_W)) u_gen (
      .clk(clk), .rst(rst),
      .run(ctrl_q[n*FIELD_W + B_RUN]),
      .tick(rate_tick[n]),
      .high_cfg(high_q[n]), .per_cfg(per_q[n]),
      .wave_o(wave_w[n]), .cnt_o(cnt_w[n]), .act_per_o(act_per_w[n])
    );

    pwm2_pad u_pad (
      .clk(clk), .rst(rst),
      .run(ctrl_q[n*FIELD_W + B_RUN]),
      .force_hi(ctrl_q[n*FIELD_W + B_FORCE]),
      .oe_n(ctrl_q[n*FIELD_W + B_OE_N]),
      .open_drain(ctrl_q[n*FIELD_W + B_ODRAIN]),
      .use_const(sel_q[n]),
      .wave(wave_w[n]),
      .var_in(var_sig[n]),
      .pin_o(pwm_out[n]),
      .oe_o(pad_oe[n])
    );
  end
endmodule

module pwm2_ctrl_chk
  import pwm2_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH*FIELD_W-1:0]    ctrl,
  input logic [NUM_CH-1:0]            sel,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] act_per,
  input logic [NUM_CH-1:0]            var_sig,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            pad_oe
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R5
    stopped_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !ctrl[n*FIELD_W + B_RUN] |=> cnt[n] == '0);
    // R3
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (rst)
      cnt[n] <= act_per[n]);
    // R9
    od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl[n*FIELD_W + B_ODRAIN] |=> !pwm_out[n]);
    // R8
    drive_off_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl[n*FIELD_W + B_OE_N] |=> !pad_oe[n]);
    // R6
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl[n*FIELD_W + B_RUN] && ctrl[n*FIELD_W + B_FORCE] &&
       !ctrl[n*FIELD_W + B_ODRAIN] && sel[n]) |=> pwm_out[n]);
    // R7
    raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (!sel[n] && !ctrl[n*FIELD_W + B_ODRAIN]) |=> pwm_out[n] == $past(var_sig[n]));
  end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .sel(sel_q), .cnt(cnt_w),
  .act_per(act_per_w), .var_sig(var_sig), .pwm_out(pwm_out), .pad_oe(pad_oe)
);

// File: tb/sim_pwm2_ctrl.sv
`timescale 1ns/1ps
module sim_pwm2_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  rate_tick = '0;
  logic [1:0]  var_sig = '0;
  logic [1:0]  pwm_out;
  logic [1:0]  pad_oe;

  int checks = 0;
  int fails  = 0;
  int tdiv [2] = '{0, 0};
  int tcnt [2] = '{0, 0};
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm2_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rate_tick(rate_tick), .var_sig(var_sig), .pwm_out(pwm_out), .pad_oe(pad_oe)
  );

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (tdiv[c] == 0) begin
        rate_tick[c] <= 1'b0;
      end else begin
        rate_tick[c] <= (tcnt[c] == 0);
        tcnt[c] = (tcnt[c] + 1 >= tdiv[c]) ? 0 : tcnt[c] + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic count_hi(input int ch, input int n, output int hp, output int ho);
    hp = 0; ho = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hp += int'(pwm_out[ch]);
      ho += int'(pad_oe[ch]);
    end
  endtask

  task automatic t_reset();
    int d;
    chk("R1 reset pwm_out", int'(pwm_out), 0);
    chk("R1 reset pad_oe", int'(pad_oe), 0);
    rd('h00, d); chk("R1 reset control", d, 'h22);
    rd('h04, d); chk("R1 reset selector", d, 'h11);
    rd('h18, d); chk("R1 reset high0", d, 0);
  endtask

  task automatic t_regmap();
    int d;
    wr('h18, 'h1A5); rd('h18, d); chk("R1 high0 readback 8 bits", d, 'hA5);
    wr('h24, 'h3C);  rd('h24, d); chk("R1 per1 readback", d, 'h3C);
    wr('h04, 'hFFFF_FFFF); rd('h04, d); chk("R1 selector bits 0 and 4", d, 'h11);
    wr('h00, 'h2A);  rd('h00, d); chk("R1 control readback", d, 'h2A);
    wr('h00, 'h22);
  endtask

  task automatic t_unmapped();
    int d;
    wr('h08, 'h77); rd('h08, d); chk("R2 unmapped read zero", d, 0);
    wr('h30, 'hFF); rd('h30, d); chk("R2 unmapped 0x30 read zero", d, 0);
    rd('h00, d); chk("R2 control untouched", d, 'h22);
    rd('h18, d); chk("R2 high0 untouched", d, 'hA5);
    rd('h24, d); chk("R2 per1 untouched", d, 'h3C);
  endtask

  task automatic t_duty();
    int hp, ho;
    tdiv[0] = 1;
    wr('h18, 3); wr('h1C, 9); wr('h00, 'h21);
    wait_n(30); count_hi(0, 40, hp, ho);
    chk("R3 ch0 high 3 of 10", hp, 12);
    chk("R8 ch0 drive enabled", ho, 40);
    wr('h18, 7);
    wait_n(30); count_hi(0, 40, hp, ho);
    chk("R3 ch0 high 7 of 10", hp, 28);
    wr('h00, 'h22);
    tdiv[1] = 3;
    wr('h20, 2); wr('h24, 4); wr('h00, 'h12);
    wait_n(40); count_hi(1, 45, hp, ho);
    chk("R3 ch1 high 2 of 5 at tick div 3", hp, 18);
    wr('h00, 'h22); tdiv[1] = 0;
  endtask

  task automatic t_full();
    int hp, ho;
    wr('h18, 'hFF); wr('h1C, 'hFE); wr('h00, 'h21);
    wait_n(10); count_hi(0, 100, hp, ho);
    chk("R4 high beyond period constant high", hp, 100);
  endtask

  task automatic t_stop_force();
    int hp, ho;
    wr('h18, 5); wr('h1C, 9); wr('h00, 'h20);
    wait_n(5); count_hi(0, 30, hp, ho);
    chk("R5 stopped channel low", hp, 0);
    wr('h18, 0); wr('h00, 'h25);
    wait_n(5); count_hi(0, 30, hp, ho);
    chk("R6 force high", hp, 30);
    wr('h00, 'h22);
    wait_n(3); count_hi(0, 5, hp, ho);
    chk("R8 drive disabled", ho, 0);
  endtask

  task automatic t_raw();
    bit pat [5] = '{1, 0, 1, 1, 0};
    wr('h04, 'h10); wr('h00, 'h20);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); var_sig[0] = pat[i];
      @(negedge clk);
      chk("R7 raw path follows var_sig", int'(pwm_out[0]), int'(pat[i]));
    end
    var_sig[0] = 1'b0;
    wr('h04, 'h11);
  endtask

  task automatic t_odrain();
    int hp, ho;
    tdiv[0] = 1;
    wr('h18, 3); wr('h1C, 7); wr('h00, 'h29);
    wait_n(30); count_hi(0, 40, hp, ho);
    chk("R9 open drain never high", hp, 0);
    chk("R9 open drain enable while low", ho, 25);
    wr('h00, 'h22);
  endtask

  task automatic t_reload();
    int hp, ho;
    tdiv[0] = 0;
    wr('h00, 'h22);
    wr('h18, 3); wr('h1C, 4);
    wr('h00, 'h21);
    wait_n(2); count_hi(0, 6, hp, ho);
    chk("R11 no ticks level held", hp, 6);
    wr('h18, 0);
    wait_n(1); count_hi(0, 4, hp, ho);
    chk("R10 new high-time waits for period end", hp, 4);
    tdiv[0] = 1;
    wait_n(20); count_hi(0, 10, hp, ho);
    chk("R10 new high-time after period end", hp, 0);
    wr('h00, 'h22); tdiv[0] = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    t_reset();
    t_regmap();
    t_unmapped();
    t_duty();
    t_full();
    t_stop_force();
    t_raw();
    t_odrain();
    t_reload();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule